// File: doc/BRIEF.md
# Cipher DMA Feed Controller

This block sits between system memory and a block-cipher engine and keeps the engine fed. A receive channel fetches words from memory and pushes them into a small input FIFO that the cipher drains. A transmit channel pops the cipher's results from an output FIFO and stores them back to memory. Software programs each channel with a start byte address and a byte length. Writing the length starts the channel at once, so the address has to be written first. Chaining of scattered buffers is left to software: each finished channel raises its own interrupt source, and the handler reprograms the channel.

The host side is a 32-bit register bus. A write takes effect at the clock edge where `bus_wr` is sampled high, and reads are combinational on `bus_addr`. The memory side and both cipher-side paths are valid/ready streams, and a word moves at each rising edge where valid and ready are both high. The memory read stream returns `rd_data` in the same cycle the request is accepted. The controller raises `rd_valid` only when the input FIFO has room, and `wr_valid` only when the output FIFO holds data. Once raised, a request keeps its address until it is accepted. `cin_valid` means the input FIFO is not empty, and `cout_ready` means the output FIFO is not full. Memory and the cipher may hold their ready low for any number of cycles.

The interrupt unit tracks four sources: receive done (bit 3), transmit done (bit 2), and two unused sources (bits 1 and 0) tied low. A latched status word, an enable mask and a pending view drive one level interrupt line.

Top module: `cipher_feed_ctrl`

## Requirements
- R1: After reset, every register reads 0 except FIFO status, which reads 0x55 (all paths empty). `irq`, `len_err`, `rd_valid`, `wr_valid` and `cin_valid` are low.
- R2: A write to the receive length register (0x24) starts the receive channel, using the address in 0x20. The length must be non-zero and a multiple of 16, and the channel must be idle. The channel then reads length/4 words from consecutive word addresses and delivers them to the cipher input in order. A length write to a busy channel is ignored.
- R3: A write to the transmit length register (0x34), using the address in 0x30, stores length/4 cipher output words to consecutive word addresses in order, with the same checks as R2. `wr_valid` is high only while the output FIFO holds a word.
- R4: Bit 1 of a channel control register (0x28 receive, 0x38 transmit) reverses the byte order of every 32-bit word that channel moves.
- R5: A length write of zero, or of a value that is not a multiple of 16, raises `len_err` for the one cycle after the write and starts nothing.
- R6: Status register 0x00 bit 3 sets when the receive channel moves its last word, and bit 2 sets when the transmit channel moves its last word. The channel is then idle. Bits 1 and 0 stay 0.
- R7: Writing 1s to 0x04 adds them to the enable mask, and writing 1s to 0x08 removes them. Both addresses read back the mask.
- R8: Register 0x0C reads status AND mask, and `irq` is high exactly when that value is non-zero.
- R9: Writing to 0x0C clears every status bit that is 1 in the written value. A completion in the same cycle as the clear leaves its bit set.
- R10: FIFO status 0x10 reads bit 7 input full, bit 6 input empty, bit 5 output full and bit 4 output empty. Bits 3..0 read 0101. The receive channel issues no read while the input FIFO is full.
- R11: Writing bit 0 = 1 to a channel control register empties that channel's FIFO at that edge. In the control register read-back, bit 0 is always 0 and bit 1 shows the stored swap setting.
- R12: The FIFO control register 0x14 stores and returns its low 3 bits. The address and length registers return the value last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr |
| rd_valid | output | 1 | Memory read request valid |
| rd_ready | input | 1 | Memory accepts the read; rd_data valid this cycle |
| rd_addr | output | AW | Memory read byte address |
| rd_data | input | 32 | Memory read data |
| wr_valid | output | 1 | Memory write request valid |
| wr_ready | input | 1 | Memory accepts the write |
| wr_addr | output | AW | Memory write byte address |
| wr_data | output | 32 | Memory write data |
| cin_valid | output | 1 | Word available to the cipher |
| cin_ready | input | 1 | Cipher takes the word |
| cin_data | output | 32 | Word to the cipher |
| cout_valid | input | 1 | Cipher result available |
| cout_ready | output | 1 | Output FIFO has room |
| cout_data | input | 32 | Cipher result word |
| irq | output | 1 | Level interrupt |
| len_err | output | 1 | One-cycle flag for a rejected length |

## Verification
Register writes take effect at the edge that samples them, and reads are combinational, so the bench reads right after that edge. `len_err` is due one edge after the bad write. A channel's first request appears right after the edge that took the length, and its status bit is set at the edge that accepts the last word. The same-cycle clear test therefore counts four edges from the length write and places the clear on that exact edge. All driving and sampling happens on falling edges, half a period away from the active edge. Completion is found by polling status with a bounded wait rather than by a fixed delay.

// File: rtl/feed_pkg.sv
package feed_pkg;
  localparam logic [7:0] A_STAT    = 8'h00;
  localparam logic [7:0] A_ENSET   = 8'h04;
  localparam logic [7:0] A_ENCLR   = 8'h08;
  localparam logic [7:0] A_PEND    = 8'h0C;
  localparam logic [7:0] A_FSTAT   = 8'h10;
  localparam logic [7:0] A_FCTL    = 8'h14;
  localparam logic [7:0] A_RX_ADDR = 8'h20;
  localparam logic [7:0] A_RX_LEN  = 8'h24;
  localparam logic [7:0] A_RX_CTL  = 8'h28;
  localparam logic [7:0] A_TX_ADDR = 8'h30;
  localparam logic [7:0] A_TX_LEN  = 8'h34;
  localparam logic [7:0] A_TX_CTL  = 8'h38;

  localparam int NSRC = 4;

  function automatic logic [31:0] swap32(input logic [31:0] w, input logic en);
    return en ? {w[7:0], w[15:8], w[23:16], w[31:24]} : w;
  endfunction
endpackage

// File: rtl/feed_fifo.sv
module feed_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] pdata,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic          full,
  output logic          empty
);
  localparam int PW = $clog2(DEPTH);

  logic [DW-1:0] store [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic [PW:0]   cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (push) wptr <= wptr + 1'b1;
      if (pop)  rptr <= rptr + 1'b1;
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) store[wptr] <= pdata;
  end

  assign head  = store[rptr];
  assign full  = (cnt == (PW+1)'(DEPTH));
  assign empty = (cnt == '0);

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  // R10
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/feed_dma_chan.sv
module feed_dma_chan #(
  parameter int AW    = 32,
  parameter int LEN_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [AW-1:0]    start_addr,
  input  logic [LEN_W-1:0] start_len,
  input  logic             fifo_ok,
  input  logic             mem_ready,
  output logic             busy,
  output logic             req_valid,
  output logic [AW-1:0]    req_addr,
  output logic             beat,
  output logic             done
);
  localparam int CNT_W = LEN_W - 2;

  logic [CNT_W-1:0] remain;
  logic [AW-1:0]    addr_q;
  logic             busy_q;

  assign busy      = busy_q;
  assign req_valid = busy_q && fifo_ok;
  assign req_addr  = addr_q;
  assign beat      = req_valid && mem_ready;
  assign done      = beat && (remain == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      addr_q <= '0;
      remain <= '0;
    end else if (start && !busy_q) begin
      busy_q <= 1'b1;
      addr_q <= start_addr;
      remain <= start_len[LEN_W-1:2];
    end else if (beat) begin
      addr_q <= addr_q + AW'(4);
      remain <= remain - 1'b1;
      if (done) busy_q <= 1'b0;
    end
  end

  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy_q) |=> (busy_q && req_addr == $past(start_addr)));
  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !done) |=> (req_addr == $past(req_addr) + AW'(4)));
  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !mem_ready) |=> $stable(req_addr));
  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy_q);
endmodule

// File: rtl/feed_irq.sv
module feed_irq #(
  parameter int NSRC = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] ev,
  input  logic            en_set,
  input  logic            en_clr,
  input  logic            pend_clr,
  input  logic [NSRC-1:0] wmask,
  output logic [NSRC-1:0] raw,
  output logic [NSRC-1:0] mask,
  output logic [NSRC-1:0] pend,
  output logic            irq
);
  logic [NSRC-1:0] clr_bits;

  assign clr_bits = pend_clr ? wmask : '0;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        raw[i]  <= 1'b0;
        mask[i] <= 1'b0;
      end else begin
        raw[i] <= ev[i] | (raw[i] & ~clr_bits[i]);
        if (en_set && wmask[i])      mask[i] <= 1'b1;
        else if (en_clr && wmask[i]) mask[i] <= 1'b0;
      end
    end
  end

  assign pend = raw & mask;
  assign irq  = |pend;

  // R9
  ev_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev) |=> ((raw & $past(ev)) == $past(ev)));
  // R9
  clr_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_clr && !(|ev)) |=> ((raw & $past(wmask)) == '0));
  // R7
  mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_set |=> ((mask & $past(wmask)) == $past(wmask)));
  // R7
  mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_clr |=> ((mask & $past(wmask)) == '0));
endmodule

// File: rtl/cipher_feed_ctrl.sv
module cipher_feed_ctrl
  import feed_pkg::*;
#(
  parameter int AW         = 32,
  parameter int LEN_W      = 20,
  parameter int FIFO_DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [7:0]    bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [AW-1:0] rd_addr,
  input  logic [31:0]   rd_data,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [AW-1:0] wr_addr,
  output logic [31:0]   wr_data,
  output logic          cin_valid,
  input  logic          cin_ready,
  output logic [31:0]   cin_data,
  input  logic          cout_valid,
  output logic          cout_ready,
  input  logic [31:0]   cout_data,
  output logic          irq,
  output logic          len_err
);
  // register file
  logic [AW-1:0] rx_addr_q, tx_addr_q;
  logic [31:0]   rx_len_q, tx_len_q;
  logic          rx_swap_q, tx_swap_q;
  logic [2:0]    fctl_q;
  logic          len_err_q;

  logic wr_rx_len, wr_tx_len, len_ok;
  logic rx_flush, tx_flush;

  function automatic logic length_valid(input logic [31:0] v);
    return ((v >> LEN_W) == 32'd0) && (v[3:0] == 4'd0) && (v != 32'd0);
  endfunction

  assign len_ok    = length_valid(bus_wdata);
  assign wr_rx_len = bus_wr && (bus_addr == A_RX_LEN);
  assign wr_tx_len = bus_wr && (bus_addr == A_TX_LEN);
  assign rx_flush  = bus_wr && (bus_addr == A_RX_CTL) && bus_wdata[0];
  assign tx_flush  = bus_wr && (bus_addr == A_TX_CTL) && bus_wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_addr_q <= '0;
      tx_addr_q <= '0;
      rx_len_q  <= '0;
      tx_len_q  <= '0;
      rx_swap_q <= 1'b0;
      tx_swap_q <= 1'b0;
      fctl_q    <= '0;
      len_err_q <= 1'b0;
    end else begin
      len_err_q <= (wr_rx_len || wr_tx_len) && !len_ok;
      if (bus_wr) begin
        case (bus_addr)
          A_RX_ADDR: rx_addr_q <= bus_wdata[AW-1:0];
          A_TX_ADDR: tx_addr_q <= bus_wdata[AW-1:0];
          A_RX_LEN:  rx_len_q  <= bus_wdata;
          A_TX_LEN:  tx_len_q  <= bus_wdata;
          A_RX_CTL:  rx_swap_q <= bus_wdata[1];
          A_TX_CTL:  tx_swap_q <= bus_wdata[1];
          A_FCTL:    fctl_q    <= bus_wdata[2:0];
          default: ;
        endcase
      end
    end
  end
  assign len_err = len_err_q;

  // FIFOs on each side of the cipher
  logic        rx_full, rx_empty, tx_full, tx_empty;
  logic [31:0] rx_head, tx_head;
  logic        rx_beat, tx_beat, rx_done, tx_done, rx_busy, tx_busy;

  feed_fifo #(.DW(32), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (rx_flush),
    .push  (rx_beat),
    .pdata (swap32(rd_data, rx_swap_q)),
    .pop   (cin_valid && cin_ready),
    .head  (rx_head),
    .full  (rx_full),
    .empty (rx_empty)
  );

  feed_fifo #(.DW(32), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (tx_flush),
    .push  (cout_valid && cout_ready),
    .pdata (cout_data),
    .pop   (tx_beat),
    .head  (tx_head),
    .full  (tx_full),
    .empty (tx_empty)
  );

  assign cin_valid  = !rx_empty;
  assign cin_data   = rx_head;
  assign cout_ready = !tx_full;
  assign wr_data    = swap32(tx_head, tx_swap_q);

  // DMA channels
  feed_dma_chan #(.AW(AW), .LEN_W(LEN_W)) u_rx_chan (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (wr_rx_len && len_ok),
    .start_addr (rx_addr_q),
    .start_len  (bus_wdata[LEN_W-1:0]),
    .fifo_ok    (!rx_full),
    .mem_ready  (rd_ready),
    .busy       (rx_busy),
    .req_valid  (rd_valid),
    .req_addr   (rd_addr),
    .beat       (rx_beat),
    .done       (rx_done)
  );

  feed_dma_chan #(.AW(AW), .LEN_W(LEN_W)) u_tx_chan (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (wr_tx_len && len_ok),
    .start_addr (tx_addr_q),
    .start_len  (bus_wdata[LEN_W-1:0]),
    .fifo_ok    (!tx_empty),
    .mem_ready  (wr_ready),
    .busy       (tx_busy),
    .req_valid  (wr_valid),
    .req_addr   (wr_addr),
    .beat       (tx_beat),
    .done       (tx_done)
  );

  // interrupt unit
  logic [NSRC-1:0] irq_raw, irq_mask, irq_pend;

  feed_irq #(.NSRC(NSRC)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev       ({rx_done, tx_done, 2'b00}),
    .en_set   (bus_wr && (bus_addr == A_ENSET)),
    .en_clr   (bus_wr && (bus_addr == A_ENCLR)),
    .pend_clr (bus_wr && (bus_addr == A_PEND)),
    .wmask    (bus_wdata[NSRC-1:0]),
    .raw      (irq_raw),
    .mask     (irq_mask),
    .pend     (irq_pend),
    .irq      (irq)
  );

  // read mux
  always_comb begin
    case (bus_addr)
      A_STAT:    bus_rdata = 32'(irq_raw);
      A_ENSET,
      A_ENCLR:   bus_rdata = 32'(irq_mask);
      A_PEND:    bus_rdata = 32'(irq_pend);
      A_FSTAT:   bus_rdata = {24'd0, rx_full, rx_empty, tx_full, tx_empty, 4'b0101};
      A_FCTL:    bus_rdata = {29'd0, fctl_q};
      A_RX_ADDR: bus_rdata = 32'(rx_addr_q);
      A_RX_LEN:  bus_rdata = rx_len_q;
      A_RX_CTL:  bus_rdata = {30'd0, rx_swap_q, 1'b0};
      A_TX_ADDR: bus_rdata = 32'(tx_addr_q);
      A_TX_LEN:  bus_rdata = tx_len_q;
      A_TX_CTL:  bus_rdata = {30'd0, tx_swap_q, 1'b0};
      default:   bus_rdata = 32'd0;
    endcase
  end

  // R5
  bad_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_rx_len && !len_ok && !rx_busy) |=> (len_err && !rx_busy));
  // R10
  rx_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full |-> !rd_valid);
  // R3
  tx_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !tx_empty);
endmodule

// File: tb/sim_cipher_feed_ctrl.sv
`timescale 1ns/1ps
module sim_cipher_feed_ctrl;
  localparam logic [31:0] KEYC = 32'hA5C3_0F96;

  // len[35:20] src_word[19:12] dst_word[11:4] rx_swap[3] tx_swap[2] rd_stall[1] wr_stall[0]
  localparam logic [35:0] VEC [4] = '{
    {16'd16, 8'd0,  8'd64,  4'b0000},
    {16'd32, 8'd8,  8'd80,  4'b1000},
    {16'd48, 8'd20, 8'd100, 4'b0101},
    {16'd64, 8'd40, 8'd120, 4'b1110}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        rd_valid, wr_valid, cin_valid, cout_ready, irq, len_err;
  logic        rd_ready, wr_ready, cin_ready, cout_valid;
  logic [31:0] rd_addr, wr_addr, rd_data, wr_data, cin_data, cout_data;
  logic        rd_stall = 1'b0, wr_stall = 1'b0, loop_en = 1'b1, tick = 1'b0;
  logic [31:0] mem [256];
  int          checks = 0, errors = 0;

  always #4 clk = ~clk;

  function automatic logic [31:0] src_word(input logic [31:0] a);
    return {a[9:2], 8'h5A, ~a[9:2], 8'hC3};
  endfunction
  function automatic logic [31:0] bswap(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  assign rd_data    = src_word(rd_addr);
  assign rd_ready   = !rd_stall || tick;
  assign wr_ready   = !wr_stall || tick;
  assign cout_valid = cin_valid && loop_en;
  assign cin_ready  = cout_ready && loop_en;
  assign cout_data  = cin_data ^ KEYC;

  always @(posedge clk) begin
    tick <= ~tick;
    if (wr_valid && wr_ready) mem[wr_addr[9:2]] <= wr_data;
  end

  cipher_feed_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .cin_valid(cin_valid), .cin_ready(cin_ready), .cin_data(cin_data),
    .cout_valid(cout_valid), .cout_ready(cout_ready), .cout_data(cout_data),
    .irq(irq), .len_err(len_err)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rdr(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wait_stat(input logic [3:0] want);
    logic [31:0] st;
    rdr(8'h00, st);
    for (int t = 0; t < 3000 && (st[3:0] & want) != want; t++) begin
      @(negedge clk);
      rdr(8'h00, st);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r, e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rdr(8'h00, r); chk(r == 0, "R1 status", r, 0);
    rdr(8'h04, r); chk(r == 0, "R1 mask", r, 0);
    rdr(8'h10, r); chk(r == 32'h55, "R1 fifo status", r, 32'h55);
    rdr(8'h24, r); chk(r == 0, "R1 rx len", r, 0);
    chk({irq, len_err, rd_valid, wr_valid, cin_valid} == 0, "R1 outputs",
        {27'd0, irq, len_err, rd_valid, wr_valid, cin_valid}, 0);

    // R7 enable set / clear
    wr(8'h04, 32'hC); rdr(8'h04, r); chk(r == 32'hC, "R7 set", r, 32'hC);
    wr(8'h08, 32'h4); rdr(8'h08, r); chk(r == 32'h8, "R7 clear", r, 32'h8);
    wr(8'h04, 32'h4); rdr(8'h04, r); chk(r == 32'hC, "R7 re-set", r, 32'hC);

    // R12 fifo control and address readback
    wr(8'h14, 32'hFF); rdr(8'h14, r); chk(r == 32'h7, "R12 fctl", r, 32'h7);
    wr(8'h20, 32'h1234_5670); rdr(8'h20, r); chk(r == 32'h1234_5670, "R12 rx addr", r, 32'h1234_5670);

    // vector table: R2 R3 R4 R6 R8 R9
    for (int v = 0; v < 4; v++) begin
      logic [15:0] len; logic [7:0] src, dst; logic rxs, txs;
      len = VEC[v][35:20]; src = VEC[v][19:12]; dst = VEC[v][11:4];
      rxs = VEC[v][3]; txs = VEC[v][2];
      rd_stall = VEC[v][1]; wr_stall = VEC[v][0];
      wr(8'h28, {30'd0, rxs, 1'b0});
      wr(8'h38, {30'd0, txs, 1'b0});
      wr(8'h30, 32'(dst) << 2);
      wr(8'h34, 32'(len));
      wr(8'h20, 32'(src) << 2);
      wr(8'h24, 32'(len));
      wait_stat(4'hC);
      rdr(8'h00, r); chk(r == 32'hC, "R6 both done", r, 32'hC);
      chk(!rd_valid && !wr_valid, "R6 idle", {30'd0, rd_valid, wr_valid}, 0);
      chk(irq == 1'b1, "R8 irq high", 32'(irq), 1);
      rdr(8'h24, r); chk(r == 32'(len), "R12 rx len", r, 32'(len));
      for (int i = 0; i < int'(len) / 4; i++) begin
        e = src_word((32'(src) + 32'(i)) << 2);
        if (rxs) e = bswap(e);
        e = e ^ KEYC;
        if (txs) e = bswap(e);
        chk(mem[8'(dst + 8'(i))] === e, (rxs || txs) ? "R4 swapped word" : "R2 R3 word",
            mem[8'(dst + 8'(i))], e);
      end
      rdr(8'h00, r); wr(8'h0C, r);
      rdr(8'h00, e); chk(e == 0, "R9 writeback clear", e, 0);
      chk(irq == 1'b0, "R8 irq low", 32'(irq), 0);
    end
    rd_stall = 1'b0; wr_stall = 1'b0;
    wr(8'h28, 32'd0); wr(8'h38, 32'd0);

    // R5 bad lengths
    wr(8'h24, 32'd0);
    chk(len_err == 1'b1, "R5 zero len flag", 32'(len_err), 1);
    @(negedge clk);
    chk(len_err == 1'b0 && !rd_valid, "R5 zero len no start", {30'd0, len_err, rd_valid}, 0);
    wr(8'h34, 32'd20);
    chk(len_err == 1'b1, "R5 misaligned flag", 32'(len_err), 1);
    repeat (3) @(negedge clk);
    rdr(8'h00, r); chk(r == 0 && !wr_valid, "R5 nothing started", r, 0);

    // R10 input FIFO full stalls the receive channel; R11 flush
    loop_en = 1'b0;
    wr(8'h20, 32'd0); wr(8'h24, 32'd32);
    repeat (8) @(negedge clk);
    rdr(8'h10, r); chk(r == 32'h95, "R10 rx full", r, 32'h95);
    chk(rd_valid == 1'b0, "R10 read stalled", 32'(rd_valid), 0);
    wr(8'h28, 32'h3);
    rdr(8'h10, r); chk(r[7:6] == 2'b01, "R11 rx flush empty", r, 32'h55);
    rdr(8'h28, r); chk(r == 32'h2, "R11 ctl readback", r, 32'h2);
    wr(8'h28, 32'h0);
    repeat (8) @(negedge clk);
    loop_en = 1'b1;
    repeat (8) @(negedge clk);
    rdr(8'h10, r); chk(r == 32'h65, "R10 tx full", r, 32'h65);
    wr(8'h38, 32'h1);
    rdr(8'h10, r); chk(r == 32'h55, "R11 tx flush", r, 32'h55);
    rdr(8'h00, r); chk(r == 32'h8, "R6 rx done only", r, 32'h8);
    wr(8'h0C, 32'hF);

    // R9 completion in the same cycle as a clear wins
    wr(8'h20, 32'h100);
    wr(8'h24, 32'd16);
    repeat (3) @(negedge clk);
    wr(8'h0C, 32'h8);
    rdr(8'h00, r); chk(r == 32'h8, "R9 same-cycle done kept", r, 32'h8);

    // R8 mask gates the interrupt
    chk(irq == 1'b1, "R8 enabled source", 32'(irq), 1);
    wr(8'h08, 32'h8);
    rdr(8'h0C, r); chk(r == 0, "R8 pending masked", r, 0);
    chk(irq == 1'b0, "R8 irq masked", 32'(irq), 0);
    rdr(8'h00, r); chk(r == 32'h8, "R8 status unmasked", r, 32'h8);
    wr(8'h0C, r);
    rdr(8'h00, r); chk(r == 0, "R9 clear after", r, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule